// File: doc/BRIEF.md
# Event Packet Formatter

This block turns one event's worth of corrected channel samples into a single variable-length bit packet. An event opens with a start pulse. The pulse carries the crossing tag, the mode select, the buffer-full status and four statistics words. After it come `NCH` samples, one per channel, in channel order, each with its own threshold. When the last sample is in, the block picks the packet kind and shifts the packet out one bit per clock, most significant bit of each field first. While the bits are shifted out, `pkt_valid` is high and `pkt_len` holds the packet length.

In suppressed mode, only channels above their threshold are kept. Each kept channel becomes a 10-bit record that holds the channel number and a coarse 3-bit amplitude. The block emits fixed 16-bit special packets in three cases: when too many channels fire, when the downstream buffer is full, and when an idle filler is requested. In debug mode, the block sends every raw sample after the statistics words. The storage buffer and the line serializer sit outside this block.

Top module: `evt_packet_fmt`

## Requirements
- R1: While `rst` is high and after it falls, `pkt_valid` stays low until an event or fill request is accepted.
- R2: A channel counts as a hit only when its two's-complement 6-bit sample is strictly greater than its unsigned 5-bit threshold. A sample equal to its threshold, and any negative sample, is not a hit.
- R3: In suppressed mode, when the buffer is not full and there are at most 63 hits, the packet has the form {tag[3:0], 1'b0, hits[5:0]}. One record {channel[6:0], amp[2:0]} follows for each hit, in ascending channel order. The length is 11 + 10·hits, and an event with no hits gives an 11-bit packet.
- R4: The record amplitude is the positive sample divided by 4, rounded down and clamped at 7.
- R5: In suppressed mode, when the buffer is not full and there are more than 63 hits, the packet is the 16-bit {tag, 1'b1, 3'b001, hits[7:0]} and carries no records.
- R6: When the buffer-full input is high at the start pulse, the packet is the 16-bit {tag, 1'b1, 3'b010, hits[7:0]}. This holds in either mode.
- R7: In debug mode, when the buffer is not full, the packet is {tag, cm_chans, sig_chans, rec_chans, cm_value}, 8 bits each, followed by all samples as 6-bit raw values from channel 0 upward. The length is 804 bits for 128 channels.
- R8: A fill request while idle produces the 16-bit packet {4'b1111, 1'b1, 3'b100, 8'hFF}.
- R9: While the block is not idle, start pulses and fill requests are ignored, and sample strobes are ignored while the block is idle. A start pulse wins over a fill request in the same cycle.
- R10: `pkt_valid` stays high for exactly `pkt_len` consecutive cycles. `pkt_first` marks the first bit and `pkt_last` marks the last, and `pkt_len` holds steady over the whole packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_start | input | 1 | Opens an event; the fields below are latched with it |
| evt_bcid | input | 4 | Crossing tag of the event |
| evt_nzs | input | 1 | 1 selects debug (unsuppressed) mode |
| evt_buf_full | input | 1 | Downstream buffer has no room |
| st_ncm | input | 8 | Channels used for the common-mode estimate |
| st_nsig | input | 8 | Signal channel count |
| st_nrec | input | 8 | Recovered channel count |
| st_cm | input | 8 | Common-mode value, sign in MSB |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 6 | Corrected sample, two's complement |
| smp_thr | input | 5 | Threshold for this sample's channel |
| fill_req | input | 1 | Request an idle filler packet |
| pkt_valid | output | 1 | Packet bit present |
| pkt_bit | output | 1 | Packet bit, MSB of each field first |
| pkt_first | output | 1 | First bit of a packet |
| pkt_last | output | 1 | Last bit of a packet |
| pkt_len | output | 10 | Packet length in bits |

## Verification
The hardest cases to reach are the boundary between 63 and 64 hits and the cases where a control input lands while the block is busy. The hit boundary is set up by writing sample and threshold patterns so that the count lands on an exact value. One of these patterns yields exactly 63 hits and mixes equal-to-threshold channels, negative channels and one channel at every amplitude. The busy cases are reached by raising a fill request in the middle of the sample stream and a start pulse in the middle of a packet. The bench then probes that the block sits idle: it expects silence in one case and an immediate filler packet in the other.

// File: rtl/pktfmt_pkg.sv
package pktfmt_pkg;
    localparam int BCID_W   = 4;
    localparam int CH_W     = 7;
    localparam int AMP_W    = 3;
    localparam int SMP_W    = 6;
    localparam int THR_W    = 5;
    localparam int STAT_W   = 8;
    localparam int CNT_W    = 8;
    localparam int LEN_W    = 10;
    localparam int FLAG_W   = 3;
    localparam int NORM_MAX = 63;
    localparam int HDR_MAX  = 36;
    localparam int HLEN_W   = 6;
    localparam int IW_W     = 4;
    localparam int REC_W    = CH_W + AMP_W;
    localparam int AMP_MAX  = (1 << AMP_W) - 1;

    localparam logic [FLAG_W-1:0] FLAG_DENSE = 3'b001;
    localparam logic [FLAG_W-1:0] FLAG_FULL  = 3'b010;
    localparam logic [FLAG_W-1:0] FLAG_FILL  = 3'b100;

    typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_FINISH, ST_EMIT} fmt_state_e;

    typedef struct packed {
        logic [BCID_W-1:0] bcid;
        logic              nzs;
        logic              full;
        logic [STAT_W-1:0] ncm;
        logic [STAT_W-1:0] nsig;
        logic [STAT_W-1:0] nrec;
        logic [STAT_W-1:0] cm;
    } evt_info_t;

    typedef struct packed {
        logic [HDR_MAX-1:0] hdr;
        logic [HLEN_W-1:0]  hdr_len;
        logic [CNT_W-1:0]   items;
        logic [IW_W-1:0]    item_w;
    } pkt_plan_t;

    function automatic logic is_hit(logic signed [SMP_W-1:0] s, logic [THR_W-1:0] t);
        return s > $signed({1'b0, t});
    endfunction

    function automatic logic [AMP_W-1:0] amp_reduce(logic signed [SMP_W-1:0] s);
        logic [SMP_W-1:0] q;
        q = {2'b00, s[SMP_W-1:2]};
        return (q > SMP_W'(AMP_MAX)) ? AMP_W'(AMP_MAX) : q[AMP_W-1:0];
    endfunction

    function automatic pkt_plan_t plan_special(logic [BCID_W-1:0] bcid,
                                               logic [FLAG_W-1:0] flag,
                                               logic [CNT_W-1:0] cnt);
        pkt_plan_t p;
        p.hdr     = {bcid, 1'b1, flag, cnt, 20'd0};
        p.hdr_len = HLEN_W'(16);
        p.items   = '0;
        p.item_w  = IW_W'(REC_W);
        return p;
    endfunction
endpackage

// File: rtl/pf_collect.sv
module pf_collect
    import pktfmt_pkg::*;
#(
    parameter int NCH = 128,
    localparam int IDX_W = $clog2(NCH),
    localparam int CW = $clog2(NCH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    wr_en,
    input  logic signed [SMP_W-1:0] smp,
    input  logic [THR_W-1:0]        thr,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [CW-1:0]           hit_cnt,
    output logic                    done_pulse,
    output logic [REC_W-1:0]        rd_rec,
    output logic [SMP_W-1:0]        rd_smp
);
    localparam int REC_D  = NORM_MAX + 1;
    localparam int REC_AW = $clog2(REC_D);

    logic [IDX_W-1:0] wcnt;
    logic [SMP_W-1:0] smp_mem [NCH];
    logic [REC_W-1:0] rec_mem [REC_D];
    logic             hit;

    assign hit        = is_hit(smp, thr);
    assign done_pulse = wr_en && (wcnt == IDX_W'(NCH - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wcnt    <= '0;
            hit_cnt <= '0;
        end else if (wr_en) begin
            wcnt <= wcnt + 1'b1;
            if (hit) hit_cnt <= hit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) smp_mem[wcnt] <= smp;
        if (wr_en && hit && (hit_cnt < CW'(REC_D)))
            rec_mem[hit_cnt[REC_AW-1:0]] <= {CH_W'(wcnt), amp_reduce(smp)};
    end

    assign rd_rec = (rd_idx < IDX_W'(REC_D)) ? rec_mem[rd_idx[REC_AW-1:0]] : '0;
    assign rd_smp = smp_mem[rd_idx];
endmodule

// File: rtl/pf_emit.sv
module pf_emit
    import pktfmt_pkg::*;
#(
    parameter int IW = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  pkt_plan_t        plan,
    input  logic [REC_W-1:0] item_data,
    output logic [IW-1:0]    item_idx,
    output logic             bit_out,
    output logic             valid,
    output logic             first,
    output logic             last,
    output logic [LEN_W-1:0] len
);
    logic [HDR_MAX-1:0] hdr_sr;
    logic [HLEN_W-1:0]  hdr_left;
    logic [REC_W-1:0]   item_sr;
    logic [IW_W-1:0]    bit_left;
    logic [IW_W-1:0]    item_w_q;
    logic [LEN_W-1:0]   rem;
    logic [LEN_W-1:0]   total;
    logic               in_hdr;
    logic               fresh;

    assign total  = LEN_W'(plan.hdr_len) + LEN_W'(plan.items) * LEN_W'(plan.item_w);
    assign valid  = (rem != '0);
    assign in_hdr = (hdr_left != '0);
    assign fresh  = !in_hdr && (bit_left == '0);
    assign bit_out = in_hdr ? hdr_sr[HDR_MAX-1]
                   : (fresh ? item_data[REC_W-1] : item_sr[REC_W-1]);
    assign last   = (rem == LEN_W'(1));
    assign first  = valid && (rem == len);

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_sr   <= '0;
            hdr_left <= '0;
            item_sr  <= '0;
            bit_left <= '0;
            item_w_q <= '0;
            rem      <= '0;
            len      <= '0;
            item_idx <= '0;
        end else if (load) begin
            hdr_sr   <= plan.hdr;
            hdr_left <= plan.hdr_len;
            item_w_q <= plan.item_w;
            bit_left <= '0;
            item_idx <= '0;
            rem      <= total;
            len      <= total;
        end else if (valid) begin
            rem <= rem - 1'b1;
            if (in_hdr) begin
                hdr_sr   <= {hdr_sr[HDR_MAX-2:0], 1'b0};
                hdr_left <= hdr_left - 1'b1;
            end else if (fresh) begin
                item_sr  <= {item_data[REC_W-2:0], 1'b0};
                bit_left <= item_w_q - 1'b1;
                item_idx <= item_idx + 1'b1;
            end else begin
                item_sr  <= {item_sr[REC_W-2:0], 1'b0};
                bit_left <= bit_left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/evt_packet_fmt.sv
module evt_packet_fmt
    import pktfmt_pkg::*;
#(
    parameter int NCH = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_start,
    input  logic [3:0]        evt_bcid,
    input  logic              evt_nzs,
    input  logic              evt_buf_full,
    input  logic [7:0]        st_ncm,
    input  logic [7:0]        st_nsig,
    input  logic [7:0]        st_nrec,
    input  logic [7:0]        st_cm,
    input  logic              smp_valid,
    input  logic [5:0]        smp_data,
    input  logic [4:0]        smp_thr,
    input  logic              fill_req,
    output logic              pkt_valid,
    output logic              pkt_bit,
    output logic              pkt_first,
    output logic              pkt_last,
    output logic [9:0]        pkt_len
);
    localparam int IDX_W = $clog2(NCH);
    localparam int CW    = $clog2(NCH + 1);

    fmt_state_e       state, state_nx;
    evt_info_t        info;
    logic             clr, wr_en, done_pulse, em_load;
    logic [CW-1:0]    hit_cnt;
    logic [CNT_W-1:0] cnt8;
    logic [REC_W-1:0] rd_rec, item_data;
    logic [SMP_W-1:0] rd_smp;
    logic [IDX_W-1:0] em_idx;
    pkt_plan_t        plan;

    assign clr   = (state == ST_IDLE) && evt_start;
    assign wr_en = (state == ST_COLLECT) && smp_valid;
    assign cnt8  = CNT_W'(hit_cnt);

    pf_collect #(.NCH(NCH)) u_collect (
        .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en),
        .smp(smp_data), .thr(smp_thr), .rd_idx(em_idx),
        .hit_cnt(hit_cnt), .done_pulse(done_pulse),
        .rd_rec(rd_rec), .rd_smp(rd_smp)
    );

    always_comb begin
        state_nx = state;
        em_load  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (evt_start) state_nx = ST_COLLECT;
                else if (fill_req) begin
                    em_load  = 1'b1;
                    state_nx = ST_EMIT;
                end
            end
            ST_COLLECT: if (done_pulse) state_nx = ST_FINISH;
            ST_FINISH: begin
                em_load  = 1'b1;
                state_nx = ST_EMIT;
            end
            ST_EMIT: if (pkt_last) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        if (state == ST_IDLE) begin
            plan = plan_special(4'hF, FLAG_FILL, 8'hFF);
        end else if (info.full) begin
            plan = plan_special(info.bcid, FLAG_FULL, cnt8);
        end else if (info.nzs) begin
            plan.hdr     = {info.bcid, info.ncm, info.nsig, info.nrec, info.cm};
            plan.hdr_len = HLEN_W'(HDR_MAX);
            plan.items   = CNT_W'(NCH);
            plan.item_w  = IW_W'(SMP_W);
        end else if (hit_cnt > CW'(NORM_MAX)) begin
            plan = plan_special(info.bcid, FLAG_DENSE, cnt8);
        end else begin
            plan.hdr     = {info.bcid, 1'b0, cnt8[5:0], 25'd0};
            plan.hdr_len = HLEN_W'(11);
            plan.items   = cnt8;
            plan.item_w  = IW_W'(REC_W);
        end
    end

    assign item_data = info.nzs ? {rd_smp, {(REC_W-SMP_W){1'b0}}} : rd_rec;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            info  <= '0;
        end else begin
            state <= state_nx;
            if (clr)
                info <= '{bcid: evt_bcid, nzs: evt_nzs, full: evt_buf_full,
                          ncm: st_ncm, nsig: st_nsig, nrec: st_nrec, cm: st_cm};
        end
    end

    pf_emit #(.IW(IDX_W)) u_emit (
        .clk(clk), .rst(rst), .load(em_load), .plan(plan),
        .item_data(item_data), .item_idx(em_idx),
        .bit_out(pkt_bit), .valid(pkt_valid), .first(pkt_first),
        .last(pkt_last), .len(pkt_len)
    );
endmodule

// File: rtl/evt_packet_fmt_sva.sv
module evt_packet_fmt_sva (
    input logic       clk,
    input logic       rst,
    input logic       pkt_valid,
    input logic       pkt_first,
    input logic       pkt_last,
    input logic [9:0] pkt_len
);
    a_r10_first_on_start: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !$past(pkt_valid)) |-> pkt_first);

    a_r10_contiguous: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_last) |=> (pkt_valid && $stable(pkt_len)));

    a_r10_gap_after_last: assert property (@(posedge clk) disable iff (rst)
        pkt_last |=> !pkt_valid);

    a_r10_marks_inside: assert property (@(posedge clk) disable iff (rst)
        (pkt_first || pkt_last) |-> pkt_valid);

    a_r3_len_form: assert property (@(posedge clk) disable iff (rst)
        pkt_first |-> ((pkt_len == 10'd16) || (pkt_len == 10'd804) ||
                       ((pkt_len >= 10'd11) && (pkt_len <= 10'd641) &&
                        (((pkt_len - 10'd11) % 10'd10) == 10'd0))));
endmodule

bind evt_packet_fmt evt_packet_fmt_sva u_sva (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_first(pkt_first),
    .pkt_last(pkt_last), .pkt_len(pkt_len)
);

// File: tb/evt_packet_fmt_test.sv
module evt_packet_fmt_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt_start = 0, evt_nzs = 0, evt_buf_full = 0;
    logic [3:0] evt_bcid = '0;
    logic [7:0] st_ncm = '0, st_nsig = '0, st_nrec = '0, st_cm = '0;
    logic       smp_valid = 0, fill_req = 0;
    logic [5:0] smp_data = '0;
    logic [4:0] smp_thr = '0;
    logic       pkt_valid, pkt_bit, pkt_first, pkt_last;
    logic [9:0] pkt_len;

    always #2 clk = ~clk;

    evt_packet_fmt uut (
        .clk(clk), .rst(rst), .evt_start(evt_start), .evt_bcid(evt_bcid),
        .evt_nzs(evt_nzs), .evt_buf_full(evt_buf_full), .st_ncm(st_ncm),
        .st_nsig(st_nsig), .st_nrec(st_nrec), .st_cm(st_cm),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_thr(smp_thr),
        .fill_req(fill_req), .pkt_valid(pkt_valid), .pkt_bit(pkt_bit),
        .pkt_first(pkt_first), .pkt_last(pkt_last), .pkt_len(pkt_len)
    );

    int checks = 0, errors = 0;
    logic [5:0] s_arr [128];
    logic [4:0] t_arr [128];
    logic exp_b [1024];
    logic cap_b [1024];
    int exp_n, cap_n, cap_len0;
    bit frame_ok, cap_done;

    task automatic check(bit ok, string req, string what, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic push(int v, int w);
        for (int i = w - 1; i >= 0; i--) begin
            exp_b[exp_n] = v[i];
            exp_n++;
        end
    endtask

    function automatic int sval(int ch);
        return s_arr[ch][5] ? int'(s_arr[ch]) - 64 : int'(s_arr[ch]);
    endfunction

    task automatic build_exp(int bcid, bit nzs, bit full, int ncm, int nsig, int nrec, int cm);
        int n = 0;
        exp_n = 0;
        for (int ch = 0; ch < 128; ch++) if (sval(ch) > int'(t_arr[ch])) n++;
        if (full) begin
            push(bcid, 4); push(1, 1); push(2, 3); push(n, 8);
        end else if (nzs) begin
            push(bcid, 4); push(ncm, 8); push(nsig, 8); push(nrec, 8); push(cm, 8);
            for (int ch = 0; ch < 128; ch++) push(int'(s_arr[ch]), 6);
        end else if (n > 63) begin
            push(bcid, 4); push(1, 1); push(1, 3); push(n, 8);
        end else begin
            push(bcid, 4); push(0, 1); push(n, 6);
            for (int ch = 0; ch < 128; ch++) begin
                if (sval(ch) > int'(t_arr[ch])) begin
                    int a = sval(ch) / 4;
                    if (a > 7) a = 7;
                    push(ch, 7); push(a, 3);
                end
            end
        end
    endtask

    task automatic build_fill();
        exp_n = 0;
        push(15, 4); push(1, 1); push(4, 3); push(255, 8);
    endtask

    task automatic run_event(int bcid, bit nzs, bit full, int ncm, int nsig, int nrec,
                             int cm, int fill_at, bit fill_with_start);
        @(negedge clk);
        evt_start = 1; evt_bcid = 4'(bcid); evt_nzs = nzs; evt_buf_full = full;
        st_ncm = 8'(ncm); st_nsig = 8'(nsig); st_nrec = 8'(nrec); st_cm = 8'(cm);
        fill_req = fill_with_start;
        @(negedge clk);
        evt_start = 0; fill_req = 0;
        for (int ch = 0; ch < 128; ch++) begin
            smp_valid = 1; smp_data = s_arr[ch]; smp_thr = t_arr[ch];
            fill_req = (ch == fill_at);
            @(negedge clk);
        end
        smp_valid = 0; fill_req = 0;
    endtask

    task automatic capture(int inject_at);
        int guard = 0;
        cap_n = 0; cap_done = 0; frame_ok = 1; cap_len0 = -1;
        while (!cap_done && guard < 3000) begin
            if (pkt_valid) begin
                if (cap_n == 0) begin
                    cap_len0 = int'(pkt_len);
                    if (!pkt_first) frame_ok = 0;
                end else begin
                    if (pkt_first) frame_ok = 0;
                    if (int'(pkt_len) != cap_len0) frame_ok = 0;
                end
                if (cap_n < 1024) cap_b[cap_n] = pkt_bit;
                cap_n++;
                if (pkt_last) cap_done = 1;
            end else if (cap_n != 0) frame_ok = 0;
            evt_start = (inject_at >= 0) && pkt_valid && (cap_n - 1 == inject_at);
            @(negedge clk);
            guard++;
        end
        evt_start = 0;
    endtask

    task automatic check_pkt(string req);
        int bad = -1;
        check(cap_done, req, "packet completed", int'(cap_done), 1);
        check(cap_n == exp_n, req, "packet length in bits", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n && i < 1024; i++)
            if (bad < 0 && cap_b[i] !== exp_b[i]) bad = i;
        check(bad < 0, req, "first differing bit index", bad, -1);
        check(cap_len0 == exp_n, "R10", "pkt_len port", cap_len0, exp_n);
        check(frame_ok, "R10", "first/contiguous/stable framing", int'(frame_ok), 1);
    endtask

    task automatic quiet(int n, string req);
        bit seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (pkt_valid) seen = 1;
        end
        check(!seen, req, "pkt_valid while expected idle", int'(seen), 0);
    endtask

    initial begin
        repeat (600000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, got 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(pkt_valid == 1'b0, "R1", "pkt_valid during reset", int'(pkt_valid), 0);
        rst = 0;
        quiet(6, "R1");

        // R9: sample strobes while idle have no effect
        smp_valid = 1; smp_data = 6'd31; smp_thr = 5'd0;
        repeat (6) @(negedge clk);
        smp_valid = 0;
        quiet(4, "R9");

        // R3: zero hits (values at or below threshold, negatives)
        for (int ch = 0; ch < 128; ch++) begin
            s_arr[ch] = (ch % 2 == 1) ? 6'h3C : ((ch % 3 == 0) ? 6'd3 : 6'd2);
            t_arr[ch] = 5'd3;
        end
        run_event(5, 0, 0, 0, 0, 0, 0, -1, 0);
        capture(-1); build_exp(5, 0, 0, 0, 0, 0, 0); check_pkt("R3");

        // R2 and R4: exactly 63 hits, amplitude sweep, equal and negative samples
        for (int ch = 0; ch < 128; ch++) begin
            if (ch < 32) begin s_arr[ch] = 6'(ch); t_arr[ch] = 5'd0; end
            else if (ch < 64) begin s_arr[ch] = 6'(-(ch - 31)); t_arr[ch] = 5'd0; end
            else if (ch < 96) begin s_arr[ch] = 6'(ch - 64); t_arr[ch] = 5'(ch - 64); end
            else begin t_arr[ch] = 5'((ch - 96) % 31); s_arr[ch] = 6'(t_arr[ch] + 1); end
        end
        run_event(10, 0, 0, 0, 0, 0, 0, -1, 0);
        capture(-1); build_exp(10, 0, 0, 0, 0, 0, 0); check_pkt("R2/R4");
        check(exp_n == 641, "R3", "bench pattern gives 63 hits", exp_n, 641);

        // R5: 64 hits
        for (int ch = 0; ch < 128; ch++) begin
            s_arr[ch] = (ch < 64) ? 6'd20 : 6'h3D; t_arr[ch] = 5'd0;
        end
        run_event(3, 0, 0, 0, 0, 0, 0, -1, 0);
        capture(-1); build_exp(3, 0, 0, 0, 0, 0, 0); check_pkt("R5");

        // R5: all channels hit
        for (int ch = 0; ch < 128; ch++) begin s_arr[ch] = 6'd31; t_arr[ch] = 5'd1; end
        run_event(12, 0, 0, 0, 0, 0, 0, -1, 0);
        capture(-1); build_exp(12, 0, 0, 0, 0, 0, 0); check_pkt("R5");

        // R6: buffer full overrides both modes
        run_event(7, 0, 1, 0, 0, 0, 0, -1, 0);
        capture(-1); build_exp(7, 0, 1, 0, 0, 0, 0); check_pkt("R6");
        for (int ch = 0; ch < 128; ch++) begin s_arr[ch] = 6'(ch % 9); t_arr[ch] = 5'd4; end
        run_event(9, 1, 1, 1, 2, 3, 4, -1, 0);
        capture(-1); build_exp(9, 1, 1, 1, 2, 3, 4); check_pkt("R6");

        // R7: debug mode
        for (int ch = 0; ch < 128; ch++) begin s_arr[ch] = 6'((ch * 5) % 64); t_arr[ch] = 5'd2; end
        run_event(14, 1, 0, 8'hA5, 3, 200, 8'h80, -1, 0);
        capture(-1); build_exp(14, 1, 0, 8'hA5, 3, 200, 8'h80); check_pkt("R7");

        // R8: idle filler
        fill_req = 1; @(negedge clk); fill_req = 0;
        capture(-1); build_fill(); check_pkt("R8");

        // R2 sweep over threshold/sample mixes and modes
        for (int k = 0; k < 12; k++) begin
            bit nz = (k % 4 == 3);
            for (int ch = 0; ch < 128; ch++) begin
                t_arr[ch] = 5'((ch * 3 + k * 5) % 32);
                s_arr[ch] = 6'((ch * 11 + k * 17) % 64);
            end
            if (k >= 6) for (int ch = 0; ch < 128; ch++) t_arr[ch] = 5'(t_arr[ch] | 5'd16);
            run_event(k, nz, 0, k, k + 1, k + 2, k + 3, -1, 0);
            capture(-1); build_exp(k, nz, 0, k, k + 1, k + 2, k + 3); check_pkt("R2");
        end

        // R9: fill with start and mid-stream fill are ignored
        for (int ch = 0; ch < 128; ch++) begin s_arr[ch] = 6'(ch % 23); t_arr[ch] = 5'd17; end
        run_event(6, 0, 0, 0, 0, 0, 0, 40, 1);
        capture(-1); build_exp(6, 0, 0, 0, 0, 0, 0); check_pkt("R9");
        quiet(30, "R9");

        // R9: start pulse during emission is ignored; block is idle after it
        run_event(11, 0, 0, 0, 0, 0, 0, -1, 0);
        capture(5); build_exp(11, 0, 0, 0, 0, 0, 0); check_pkt("R9");
        fill_req = 1; @(negedge clk); fill_req = 0;
        capture(-1); build_fill(); check_pkt("R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule